// File: doc/BRIEF.md
# Binary-Field Squarer for GF(2^233)

This block squares one element of the binary extension field GF(2^233), the field used by the 233-bit binary elliptic curve. An element is a 233-bit vector in polynomial basis: bit i is the coefficient of x^i. In characteristic two the square of a polynomial has only even-power terms. The block therefore spreads the operand so that coefficient i lands on position 2i with zeros in between. This gives a 465-bit value with set bits only at even positions 0 to 464. It then folds that value back below degree 233 with a fixed XOR network derived from the field polynomial x^233 + x^74 + 1.

The arithmetic is purely combinational and finishes within one clock. A single output register holds the result. Both sides of the block are valid/ready streams. An operand is taken on any rising edge where `in_valid` and `in_ready` are both high, and its square is offered on the very next cycle. The block accepts a new operand every cycle while the consumer keeps `out_ready` high. When the consumer stalls, the held result stays frozen and `in_ready` drops, so back-pressure passes straight through to the producer with no extra buffering.

Top module: `gf233_square`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is low.
- R2: An operand accepted on a rising edge (`in_valid` and `in_ready` both high) makes `out_valid` high in the cycle that follows that edge.
- R3: The result on `out_data` equals the square of the accepted operand reduced modulo x^233 + x^74 + 1, with bit i of each vector the coefficient of x^i.
- R4: Squaring the all-zero operand yields all zeros, and squaring the value 1 (only bit 0 set) yields 1.
- R5: An operand with a single set bit at position i, where i is at most 116, yields a result with only bit 2i set.
- R6: Operands whose expansion reaches degree 233 or more are fully reduced. This includes single bits at 117, 159 and 232 and the all-ones operand.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change on the next edge.
- R8: `in_ready` is high exactly when the output register is empty or is being drained in the same cycle (`!out_valid || out_ready`). An operand offered while `in_ready` is low is ignored: the held result is unchanged.
- R9: With `out_ready` held high, an operand offered on every cycle is accepted on every cycle, and each result appears one cycle after its operand.
- R10: If no operand is accepted on an edge and the output is empty or drained on that edge, `out_valid` is low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand on `in_data` is offered |
| in_ready | output | 1 | Block can take an operand this cycle |
| in_data | input | 233 | Field element to square, bit i = coefficient of x^i |
| out_valid | output | 1 | `out_data` holds a result not yet consumed |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 233 | Reduced square, bit i = coefficient of x^i |

## Verification
The bound checker watches the handshake on every cycle. It covers the stall hold, the ready rule, the one-cycle latency, the absence of results that no operand produced, and the idle state under reset. It also checks the fixed points zero and one and the no-reduction behaviour of single low bits. Whether an arbitrary result is the correct reduced square can only be shown by the bench scenarios. These compare the outputs against an independent shift-and-add field multiply over random operands, all single low bits, and the high single bits and all-ones pattern that drive the reduction hardest.

// File: rtl/gf233_sq_pkg.sv
package gf233_sq_pkg;
  // Field degree and middle tap of the trinomial x^M + x^K + 1
  localparam int unsigned GF_DEG = 233;
  localparam int unsigned GF_TAP = 74;
endpackage

// File: rtl/gf_spread.sv
// Zero-interleave: coefficient i moves to position 2i.
module gf_spread #(
  parameter int unsigned W = 233,
  localparam int unsigned WIDE = 2 * W - 1
) (
  input  logic [W-1:0]    a,
  output logic [WIDE-1:0] wide
);
  for (genvar i = 0; i < W; i++) begin : g_even
    assign wide[2*i] = a[i];
  end
  for (genvar i = 0; i < W - 1; i++) begin : g_odd
    assign wide[2*i+1] = 1'b0;
  end
endmodule

// File: rtl/gf_fold.sv
// Reduce a degree < 2W-1 polynomial modulo x^W + x^K + 1.
// Working top-down, each term x^k (k >= W) becomes x^(k-W+K) + x^(k-W);
// the first of these may still be >= W and is folded by a later step.
module gf_fold #(
  parameter int unsigned W = 233,
  parameter int unsigned K = 74,
  localparam int unsigned WIDE = 2 * W - 1
) (
  input  logic [WIDE-1:0] wide,
  output logic [W-1:0]    res
);
  logic [WIDE-1:0] acc;

  always_comb begin
    acc = wide;
    for (int k = WIDE - 1; k >= int'(W); k--) begin
      if (acc[k]) begin
        acc[k]         = 1'b0;
        acc[k - W + K] = ~acc[k - W + K];
        acc[k - W]     = ~acc[k - W];
      end
    end
    res = acc[W-1:0];
  end
endmodule

// File: rtl/gf_hold_stage.sv
// One-entry valid/ready register stage.
module gf_hold_stage #(
  parameter int unsigned W = 233
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
    end else if (take) begin
      out_data <= in_data;
    end
  end
endmodule

// File: rtl/gf233_square.sv
module gf233_square
  import gf233_sq_pkg::*;
#(
  parameter int unsigned FIELD_W = GF_DEG,
  parameter int unsigned TAP     = GF_TAP,
  localparam int unsigned WIDE   = 2 * FIELD_W - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [FIELD_W-1:0] in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [FIELD_W-1:0] out_data
);
  logic [WIDE-1:0]    spread_w;
  logic [FIELD_W-1:0] square_w;

  gf_spread #(.W(FIELD_W)) u_spread (
    .a    (in_data),
    .wide (spread_w)
  );

  gf_fold #(.W(FIELD_W), .K(TAP)) u_fold (
    .wide (spread_w),
    .res  (square_w)
  );

  gf_hold_stage #(.W(FIELD_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (square_w),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );
endmodule

// File: rtl/gf233_square_chk.sv
module gf233_square_chk #(
  parameter int unsigned W = 233
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_data,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data
);
  localparam int unsigned HALF = (W + 1) / 2;

  logic accept;
  assign accept = in_valid && in_ready;

  always @(posedge clk) begin
    if (!rst_n) AST_RESET_IDLE: assert (!out_valid); // R1
  end

  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid); // R2

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7

  AST_READY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R8

  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && (!out_valid || out_ready)) |=> !out_valid); // R10

  AST_ZERO_SQ: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_data == '0) |=> (out_data == '0)); // R4

  AST_ONE_SQ: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_data == W'(1)) |=> (out_data == W'(1))); // R4

  AST_LOW_BIT_SPREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && $countones(in_data) == 1 && in_data[W-1:HALF] == '0)
      |=> ($countones(out_data) == 1)); // R5
endmodule

bind gf233_square gf233_square_chk #(.W(FIELD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/gf233_square_test.sv
`timescale 1ns/1ps
module gf233_square_test;
  localparam int W = 233;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         out_ready = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ready;
  logic         out_valid;
  logic [W-1:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  gf233_square uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // MSB-first shift-and-add multiply modulo x^233 + x^74 + 1
  function automatic logic [W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] r = '0;
    for (int i = W - 1; i >= 0; i--) begin
      logic top = r[W-1];
      r = r << 1;
      if (top) begin
        r[0]  = ~r[0];
        r[74] = ~r[74];
      end
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [W-1:0] ref_sq(logic [W-1:0] a);
    return ref_mul(a, a);
  endfunction

  function automatic logic [W-1:0] rnd_elem();
    logic [W-1:0] v = '0;
    for (int i = 0; i < 8; i++) v = {v[W-33:0], $urandom()};
    return v;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Offer one operand with the consumer ready, check result, then check drain.
  task automatic xfer(logic [W-1:0] d, logic [W-1:0] exp, string req);
    in_valid  = 1'b1;
    in_data   = d;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2", W'(out_valid), W'(1));
    chk(req, out_data, exp);
    @(negedge clk);
    chk("R10", W'(out_valid), W'(0));
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    chk("R1", W'(out_valid), W'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", W'(out_valid), W'(0));
    chk("R8", W'(in_ready), W'(1));

    xfer('0, '0, "R4");
    xfer(W'(1), W'(1), "R4");
    for (int i = 0; i <= 116; i++)
      xfer(W'(1) << i, W'(1) << (2 * i), "R5");
    xfer(W'(1) << 117, ref_sq(W'(1) << 117), "R6");
    xfer(W'(1) << 159, ref_sq(W'(1) << 159), "R6");
    xfer(W'(1) << 232, ref_sq(W'(1) << 232), "R6");
    xfer('1, ref_sq('1), "R6");

    // Back-to-back, consumer always ready
    for (int c = 0; c < 300; c++) begin
      logic [W-1:0] d = rnd_elem();
      in_valid = 1'b1; in_data = d; out_ready = 1'b1;
      #1 chk("R9", W'(in_ready), W'(1));
      @(negedge clk);
      chk("R9", W'(out_valid), W'(1));
      chk("R3", out_data, ref_sq(d));
    end

    // Random valid and random back-pressure against a one-entry model
    begin
      logic         ev = 1'b1;
      logic [W-1:0] ed = out_data;
      for (int c = 0; c < 600; c++) begin
        logic         v = ($urandom() % 4) != 0;
        logic         r = ($urandom() % 4) != 0;
        logic [W-1:0] d = rnd_elem();
        logic         rdy = !ev || r;
        logic         stall = ev && !r;
        in_valid = v; in_data = d; out_ready = r;
        #1 chk("R8", W'(in_ready), W'(rdy));
        @(negedge clk);
        if (v && rdy) begin
          ev = 1'b1; ed = ref_sq(d);
        end else if (r) begin
          ev = 1'b0;
        end
        chk(stall ? "R7" : "R10", W'(out_valid), W'(ev));
        if (ev) chk(stall ? "R8" : "R3", out_data, ed);
      end
    end

    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule